// File: doc/BRIEF.md
# AXI4 Register and Queue Window

This block is an AXI4 slave that exposes a flat, word-addressed window made of four consecutive segments. The lowest segment holds read-only status words (an external flag and the fill count of every receive channel). Above it sit two read-write control words that drive output pins. Above those, one word per channel gives access to a receive stream, and a read of that word pops the stream. Above those, one word per channel gives access to a transmit stream, and a write to that word pushes onto it.

Streams use valid/ready handshakes, so a read of an empty receive stream or a write to a full transmit stream stalls the matching AXI channel. A write that stays stalled for too long is ended by a watchdog. The watchdog force-accepts the beat, drops the rest of the burst and reports a slave error. Bursts may either walk the window (incrementing) or stay on one word (fixed), so a fixed burst can fill or drain a single stream. Every beat is a full bus word.

Top module: `axi_reg_queue_win`

## Requirements
- R1: With W = DATA_W/8 bytes per word and S = the smallest power of two not below N_CH+1, word index addr/W selects a segment. Words 0..S-1 are status, words S..S+1 are control, the next N_CH words are receive channels 0..N_CH-1, and the next N_CH words are transmit channels 0..N_CH-1. At most one transmit channel is offered data in any cycle.
- R2: Status word 0 reads sync_flag_i zero-extended. Status word 1+c reads the receive fill count of channel c (field c*CNT_W of rx_count_i), zero-extended. All other status words read 0.
- R3: Both control words reset to 0. A write changes only the bytes whose w_strb_i bit is set, with strobe bit b covering data bits 8b+7..8b. A read returns the current value, and ctrl_o (word 0 in the low DATA_W bits) holds its value between writes.
- R4: A read beat at receive word c returns the head of channel c and pops exactly that entry. While channel c is empty, r_valid_o stays low.
- R5: A write beat at transmit word c pushes w_data_i onto channel c. While that channel is not ready, w_ready_o stays low, until the watchdog fires.
- R6: If a transmit write stays stalled for TIMEOUT cycles, w_ready_o is forced high in the next cycle and the beat is dropped. The remaining beats of that burst are accepted at once and discarded. One B response with SLVERR (2'b10) follows the beat with w_last_i set.
- R7: With TIMEOUT = 0, a stalled transmit write waits for as long as the channel is not ready, then completes with OKAY.
- R8: An access at or beyond the top of the window, or with a nonzero byte offset inside a word, completes with OKAY. Such a read returns 0 and such a write changes nothing.
- R9: A burst of ar_len_i+1 read beats is returned in order, with r_last_o set on the final beat. Burst type 2'b00 (fixed) keeps the address, and any other type adds W per beat. r_id_o and b_id_o echo the request ID.
- R10: Every read response, and every write response not aborted by the watchdog, is OKAY (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address ready |
| aw_id_i | input | ID_W | Write ID |
| aw_addr_i | input | ADDR_W | Write byte address |
| aw_burst_i | input | 2 | Write burst type |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data ready |
| w_data_i | input | DATA_W | Write data |
| w_strb_i | input | DATA_W/8 | Write byte strobes |
| w_last_i | input | 1 | Last write beat |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response ready |
| b_id_o | output | ID_W | Write response ID |
| b_resp_o | output | 2 | Write response code |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address ready |
| ar_id_i | input | ID_W | Read ID |
| ar_addr_i | input | ADDR_W | Read byte address |
| ar_len_i | input | 8 | Read beats minus one |
| ar_burst_i | input | 2 | Read burst type |
| r_valid_o | output | 1 | Read data valid |
| r_ready_i | input | 1 | Read data ready |
| r_id_o | output | ID_W | Read ID |
| r_data_o | output | DATA_W | Read data |
| r_resp_o | output | 2 | Read response code |
| r_last_o | output | 1 | Last read beat |
| sync_flag_i | input | FLAG_W | Flag shown in status word 0 |
| rx_count_i | input | N_CH*CNT_W | Receive fill counts |
| ctrl_o | output | 2*DATA_W | Control words |
| rxq_valid_i | input | N_CH | Receive head valid |
| rxq_ready_o | output | N_CH | Receive pop |
| rxq_data_i | input | N_CH*DATA_W | Receive head data |
| txq_valid_o | output | N_CH | Transmit push valid |
| txq_ready_i | input | N_CH | Transmit space available |
| txq_data_o | output | N_CH*DATA_W | Transmit data |

## Verification
On every cycle the assertions check the following. Stream pushes and pops happen only together with an accepted W or R beat, and at most one transmit channel is driven. Pending R and B responses are held until taken, response codes are legal, and the control words change only on an accepted write. Decode contents, strobe merging, the order of popped data, the exact length of the watchdog stall, the single SLVERR after a discarded burst tail, and the unlimited wait when the watchdog is disabled are all value- and sequence-dependent. These can only be shown by the bench scenarios, which score every R beat, B response and stream push against expected lists.

// File: rtl/axi_win_pkg.sv
package axi_win_pkg;
  typedef enum logic [2:0] {SEG_STAT, SEG_CTRL, SEG_RXQ, SEG_TXQ, SEG_NONE} seg_e;
  typedef enum logic [1:0] {W_IDLE, W_DATA, W_RESP} wst_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] BURST_FIXED = 2'b00;

  function automatic int pow2ceil(int v);
    return 1 << $clog2(v);
  endfunction
endpackage

// File: rtl/axi_win_dec.sv
module axi_win_dec
  import axi_win_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_CH   = 2,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output seg_e              seg_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int WB     = DATA_W / 8;
  localparam int OFF_W  = $clog2(WB);
  localparam int WORD_W = ADDR_W - OFF_W;
  localparam int N_RS   = pow2ceil(1 + N_CH);
  localparam logic [WORD_W-1:0] CT_BEG = WORD_W'(N_RS);
  localparam logic [WORD_W-1:0] RX_BEG = WORD_W'(N_RS + 2);
  localparam logic [WORD_W-1:0] TX_BEG = WORD_W'(N_RS + 2 + N_CH);
  localparam logic [WORD_W-1:0] TOP    = WORD_W'(N_RS + 2 + 2 * N_CH);

  logic [WORD_W-1:0] word;
  logic              mis;

  assign word = addr_i[ADDR_W-1:OFF_W];
  assign mis  = (addr_i & ADDR_W'(WB - 1)) != '0;

  always_comb begin
    seg_o = SEG_NONE;
    idx_o = '0;
    if (!mis) begin
      if (word < CT_BEG) begin
        seg_o = SEG_STAT;
        idx_o = IDX_W'(word);
      end else if (word < RX_BEG) begin
        seg_o = SEG_CTRL;
        idx_o = IDX_W'(word - CT_BEG);
      end else if (word < TX_BEG) begin
        seg_o = SEG_RXQ;
        idx_o = IDX_W'(word - RX_BEG);
      end else if (word < TOP) begin
        seg_o = SEG_TXQ;
        idx_o = IDX_W'(word - TX_BEG);
      end
    end
  end
endmodule

// File: rtl/axi_win_rd.sv
module axi_win_rd
  import axi_win_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int N_CH   = 2,
  parameter int FLAG_W = 8,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ar_valid_i,
  output logic                   ar_ready_o,
  input  logic [ID_W-1:0]        ar_id_i,
  input  logic [ADDR_W-1:0]      ar_addr_i,
  input  logic [7:0]             ar_len_i,
  input  logic [1:0]             ar_burst_i,
  output logic                   r_valid_o,
  input  logic                   r_ready_i,
  output logic [ID_W-1:0]        r_id_o,
  output logic [DATA_W-1:0]      r_data_o,
  output logic [1:0]             r_resp_o,
  output logic                   r_last_o,
  input  logic [FLAG_W-1:0]      sync_flag_i,
  input  logic [N_CH*CNT_W-1:0]  rx_count_i,
  input  logic [2*DATA_W-1:0]    ctrl_i,
  input  logic [N_CH-1:0]        rxq_valid_i,
  output logic [N_CH-1:0]        rxq_ready_o,
  input  logic [N_CH*DATA_W-1:0] rxq_data_i
);
  localparam int WB = DATA_W / 8;

  logic              busy_q, fixed_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        left_q;
  seg_e              seg;
  logic [IDX_W-1:0]  idx;

  axi_win_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH), .IDX_W(IDX_W)) u_dec (
    .addr_i(addr_q), .seg_o(seg), .idx_o(idx)
  );

  assign ar_ready_o = !busy_q;
  assign r_id_o     = id_q;
  assign r_resp_o   = RESP_OKAY;
  assign r_last_o   = (left_q == 8'd0);

  always_comb begin
    r_valid_o   = 1'b0;
    r_data_o    = '0;
    rxq_ready_o = '0;
    if (busy_q) begin
      r_valid_o = 1'b1;
      case (seg)
        SEG_STAT: begin
          if (idx == '0) r_data_o = DATA_W'(sync_flag_i);
          for (int c = 0; c < N_CH; c++)
            if (idx == IDX_W'(c + 1)) r_data_o = DATA_W'(rx_count_i[c*CNT_W +: CNT_W]);
        end
        SEG_CTRL: r_data_o = ctrl_i[idx[0]*DATA_W +: DATA_W];
        SEG_RXQ: begin
          for (int c = 0; c < N_CH; c++)
            if (idx == IDX_W'(c)) begin
              r_valid_o      = rxq_valid_i[c];
              r_data_o       = rxq_data_i[c*DATA_W +: DATA_W];
              rxq_ready_o[c] = r_ready_i;
            end
        end
        default: r_data_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      fixed_q <= 1'b0;
      id_q    <= '0;
      addr_q  <= '0;
      left_q  <= '0;
    end else if (!busy_q) begin
      if (ar_valid_i) begin
        busy_q  <= 1'b1;
        id_q    <= ar_id_i;
        addr_q  <= ar_addr_i;
        left_q  <= ar_len_i;
        fixed_q <= (ar_burst_i == BURST_FIXED);
      end
    end else if (r_valid_o && r_ready_i) begin
      if (left_q == 8'd0) busy_q <= 1'b0;
      else begin
        left_q <= left_q - 8'd1;
        if (!fixed_q) addr_q <= addr_q + ADDR_W'(WB);
      end
    end
  end
endmodule

// File: rtl/axi_win_wr.sv
module axi_win_wr
  import axi_win_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int N_CH    = 2,
  parameter int IDX_W   = 2,
  parameter int TIMEOUT = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   aw_valid_i,
  output logic                   aw_ready_o,
  input  logic [ID_W-1:0]        aw_id_i,
  input  logic [ADDR_W-1:0]      aw_addr_i,
  input  logic [1:0]             aw_burst_i,
  input  logic                   w_valid_i,
  output logic                   w_ready_o,
  input  logic [DATA_W-1:0]      w_data_i,
  input  logic [DATA_W/8-1:0]    w_strb_i,
  input  logic                   w_last_i,
  output logic                   b_valid_o,
  input  logic                   b_ready_i,
  output logic [ID_W-1:0]        b_id_o,
  output logic [1:0]             b_resp_o,
  output logic [2*DATA_W-1:0]    ctrl_o,
  output logic [N_CH-1:0]        txq_valid_o,
  input  logic [N_CH-1:0]        txq_ready_i,
  output logic [N_CH*DATA_W-1:0] txq_data_o
);
  localparam int WB   = DATA_W / 8;
  localparam int TO_W = $clog2(TIMEOUT + 2);

  wst_e                   st_q;
  logic                   fixed_q, abort_q;
  logic [ID_W-1:0]        id_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [TO_W-1:0]        stall_q;
  logic [1:0][DATA_W-1:0] ctrl_q;
  seg_e                   seg;
  logic [IDX_W-1:0]       idx;
  logic                   to_hit, abort_now, stall_inc, wfire;

  axi_win_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH), .IDX_W(IDX_W)) u_dec (
    .addr_i(addr_q), .seg_o(seg), .idx_o(idx)
  );

  assign to_hit     = (TIMEOUT != 0) && (stall_q == TO_W'(TIMEOUT));
  assign txq_data_o = {N_CH{w_data_i}};
  assign b_valid_o  = (st_q == W_RESP);
  assign b_id_o     = id_q;
  assign b_resp_o   = abort_q ? RESP_SLVERR : RESP_OKAY;
  assign ctrl_o     = ctrl_q;
  assign wfire      = w_valid_i && w_ready_o;
  assign stall_inc  = (st_q == W_DATA) && !abort_q && (seg == SEG_TXQ) && w_valid_i && !w_ready_o;

  always_comb begin
    aw_ready_o  = (st_q == W_IDLE);
    w_ready_o   = 1'b0;
    txq_valid_o = '0;
    abort_now   = 1'b0;
    if (st_q == W_DATA) begin
      if (abort_q) w_ready_o = 1'b1;  // drain tail of an aborted burst
      else if (seg == SEG_TXQ) begin
        for (int c = 0; c < N_CH; c++)
          if (idx == IDX_W'(c)) begin
            txq_valid_o[c] = w_valid_i;
            w_ready_o      = txq_ready_i[c] | to_hit;
            abort_now      = w_valid_i & to_hit & ~txq_ready_i[c];
          end
      end else w_ready_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      fixed_q <= 1'b0;
      abort_q <= 1'b0;
      id_q    <= '0;
      addr_q  <= '0;
      stall_q <= '0;
      ctrl_q  <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (aw_valid_i) begin
          st_q    <= W_DATA;
          id_q    <= aw_id_i;
          addr_q  <= aw_addr_i;
          fixed_q <= (aw_burst_i == BURST_FIXED);
          abort_q <= 1'b0;
          stall_q <= '0;
        end
        W_DATA: begin
          if (wfire) begin
            stall_q <= '0;
            if (abort_now) abort_q <= 1'b1;
            if (!abort_q && seg == SEG_CTRL)
              for (int b = 0; b < WB; b++)
                if (w_strb_i[b]) ctrl_q[idx[0]][b*8 +: 8] <= w_data_i[b*8 +: 8];
            if (w_last_i) st_q <= W_RESP;
            else if (!fixed_q) addr_q <= addr_q + ADDR_W'(WB);
          end else if (stall_inc && stall_q != '1) begin
            stall_q <= stall_q + TO_W'(1);
          end
        end
        W_RESP: if (b_ready_i) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_reg_queue_win.sv
module axi_reg_queue_win
  import axi_win_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int N_CH    = 2,
  parameter int FLAG_W  = 8,
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   aw_valid_i,
  output logic                   aw_ready_o,
  input  logic [ID_W-1:0]        aw_id_i,
  input  logic [ADDR_W-1:0]      aw_addr_i,
  input  logic [1:0]             aw_burst_i,
  input  logic                   w_valid_i,
  output logic                   w_ready_o,
  input  logic [DATA_W-1:0]      w_data_i,
  input  logic [DATA_W/8-1:0]    w_strb_i,
  input  logic                   w_last_i,
  output logic                   b_valid_o,
  input  logic                   b_ready_i,
  output logic [ID_W-1:0]        b_id_o,
  output logic [1:0]             b_resp_o,
  input  logic                   ar_valid_i,
  output logic                   ar_ready_o,
  input  logic [ID_W-1:0]        ar_id_i,
  input  logic [ADDR_W-1:0]      ar_addr_i,
  input  logic [7:0]             ar_len_i,
  input  logic [1:0]             ar_burst_i,
  output logic                   r_valid_o,
  input  logic                   r_ready_i,
  output logic [ID_W-1:0]        r_id_o,
  output logic [DATA_W-1:0]      r_data_o,
  output logic [1:0]             r_resp_o,
  output logic                   r_last_o,
  input  logic [FLAG_W-1:0]      sync_flag_i,
  input  logic [N_CH*CNT_W-1:0]  rx_count_i,
  output logic [2*DATA_W-1:0]    ctrl_o,
  input  logic [N_CH-1:0]        rxq_valid_i,
  output logic [N_CH-1:0]        rxq_ready_o,
  input  logic [N_CH*DATA_W-1:0] rxq_data_i,
  output logic [N_CH-1:0]        txq_valid_o,
  input  logic [N_CH-1:0]        txq_ready_i,
  output logic [N_CH*DATA_W-1:0] txq_data_o
);
  localparam int N_RS  = pow2ceil(1 + N_CH);
  localparam int IDX_W = $clog2(N_RS);

  logic [2*DATA_W-1:0] ctrl;

  assign ctrl_o = ctrl;

  axi_win_wr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .N_CH(N_CH), .IDX_W(IDX_W), .TIMEOUT(TIMEOUT)
  ) u_wr (
    .clk_i, .rst_ni,
    .aw_valid_i, .aw_ready_o, .aw_id_i, .aw_addr_i, .aw_burst_i,
    .w_valid_i, .w_ready_o, .w_data_i, .w_strb_i, .w_last_i,
    .b_valid_o, .b_ready_i, .b_id_o, .b_resp_o,
    .ctrl_o(ctrl),
    .txq_valid_o, .txq_ready_i, .txq_data_o
  );

  axi_win_rd #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .N_CH(N_CH),
    .FLAG_W(FLAG_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_rd (
    .clk_i, .rst_ni,
    .ar_valid_i, .ar_ready_o, .ar_id_i, .ar_addr_i, .ar_len_i, .ar_burst_i,
    .r_valid_o, .r_ready_i, .r_id_o, .r_data_o, .r_resp_o, .r_last_o,
    .sync_flag_i, .rx_count_i,
    .ctrl_i(ctrl),
    .rxq_valid_i, .rxq_ready_o, .rxq_data_i
  );
endmodule

// File: rtl/axi_win_chk.sv
module axi_win_chk #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int N_CH   = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                w_valid_i,
  input logic                w_ready_o,
  input logic                b_valid_o,
  input logic                b_ready_i,
  input logic [1:0]          b_resp_o,
  input logic                ar_ready_o,
  input logic                r_valid_o,
  input logic                r_ready_i,
  input logic [ID_W-1:0]     r_id_o,
  input logic [1:0]          r_resp_o,
  input logic [2*DATA_W-1:0] ctrl_o,
  input logic [N_CH-1:0]     rxq_valid_i,
  input logic [N_CH-1:0]     rxq_ready_o,
  input logic [N_CH-1:0]     txq_valid_o,
  input logic [N_CH-1:0]     txq_ready_i
);
  AST_ONE_TX_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(txq_valid_o)); // R1

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_valid_i && w_ready_o) |=> $stable(ctrl_o)); // R3

  AST_POP_WITH_R_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxq_valid_i & rxq_ready_o) != '0 |-> (r_valid_o && r_ready_i)); // R4

  AST_PUSH_WITH_W_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txq_valid_o & txq_ready_i) != '0 |-> (w_valid_i && w_ready_o)); // R5

  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o && !b_ready_i |=> b_valid_o && $stable(b_resp_o)); // R6

  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i |=> r_valid_o && $stable(r_id_o)); // R9

  AST_NO_AR_DURING_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o |-> !ar_ready_o); // R9

  AST_R_OKAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o |-> r_resp_o == 2'b00); // R10

  AST_B_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o |-> (b_resp_o == 2'b00 || b_resp_o == 2'b10)); // R10
endmodule

bind axi_reg_queue_win axi_win_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .w_valid_i(w_valid_i), .w_ready_o(w_ready_o),
  .b_valid_o(b_valid_o), .b_ready_i(b_ready_i), .b_resp_o(b_resp_o),
  .ar_ready_o(ar_ready_o),
  .r_valid_o(r_valid_o), .r_ready_i(r_ready_i), .r_id_o(r_id_o), .r_resp_o(r_resp_o),
  .ctrl_o(ctrl_o),
  .rxq_valid_i(rxq_valid_i), .rxq_ready_o(rxq_ready_o),
  .txq_valid_o(txq_valid_o), .txq_ready_i(txq_ready_i)
);

// File: tb/tb_axi_reg_queue_win.sv
`timescale 1ns/1ps
module tb_axi_reg_queue_win;
  localparam int AW = 12, DW = 32, IW = 4, NC = 2, FW = 8, CW = 8, TO = 32;
  localparam logic [1:0] INCR = 2'b01, FIXED = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic aw_valid = 0, w_valid = 0, w_last = 0, b_ready = 1, ar_valid = 0, r_ready = 1;
  logic [IW-1:0] aw_id = 0, ar_id = 0;
  logic [AW-1:0] aw_addr = 0, ar_addr = 0;
  logic [1:0] aw_burst = 0, ar_burst = 0;
  logic [DW-1:0] w_data = 0;
  logic [3:0] w_strb = 0;
  logic [7:0] ar_len = 0;
  logic [FW-1:0] sync_flag = 0;
  logic [NC*CW-1:0] rx_count = 0;
  logic [NC-1:0] rxq_valid = 0, txq_ready = 2'b11;
  logic [NC*DW-1:0] rxq_data = 0;

  logic aw_ready, w_ready, b_valid, ar_ready, r_valid, r_last;
  logic [IW-1:0] b_id, r_id;
  logic [1:0] b_resp, r_resp;
  logic [DW-1:0] r_data;
  logic [2*DW-1:0] ctrl;
  logic [NC-1:0] rxq_ready, txq_valid;
  logic [NC*DW-1:0] txq_data;

  axi_reg_queue_win #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .N_CH(NC), .FLAG_W(FW),
                      .CNT_W(CW), .TIMEOUT(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_valid_i(aw_valid), .aw_ready_o(aw_ready), .aw_id_i(aw_id), .aw_addr_i(aw_addr),
    .aw_burst_i(aw_burst),
    .w_valid_i(w_valid), .w_ready_o(w_ready), .w_data_i(w_data), .w_strb_i(w_strb),
    .w_last_i(w_last),
    .b_valid_o(b_valid), .b_ready_i(b_ready), .b_id_o(b_id), .b_resp_o(b_resp),
    .ar_valid_i(ar_valid), .ar_ready_o(ar_ready), .ar_id_i(ar_id), .ar_addr_i(ar_addr),
    .ar_len_i(ar_len), .ar_burst_i(ar_burst),
    .r_valid_o(r_valid), .r_ready_i(r_ready), .r_id_o(r_id), .r_data_o(r_data),
    .r_resp_o(r_resp), .r_last_o(r_last),
    .sync_flag_i(sync_flag), .rx_count_i(rx_count), .ctrl_o(ctrl),
    .rxq_valid_i(rxq_valid), .rxq_ready_o(rxq_ready), .rxq_data_i(rxq_data),
    .txq_valid_o(txq_valid), .txq_ready_i(txq_ready), .txq_data_o(txq_data)
  );

  // second instance with the watchdog disabled (R7)
  logic n_aw_valid = 0, n_w_valid = 0;
  logic [DW-1:0] n_w_data = 0;
  logic [NC-1:0] n_txq_ready = 2'b00;
  logic n_aw_ready, n_w_ready, n_b_valid, n_ar_ready, n_r_valid, n_r_last;
  logic [IW-1:0] n_b_id, n_r_id;
  logic [1:0] n_b_resp, n_r_resp;
  logic [DW-1:0] n_r_data;
  logic [2*DW-1:0] n_ctrl;
  logic [NC-1:0] n_rxq_ready, n_txq_valid;
  logic [NC*DW-1:0] n_txq_data;

  axi_reg_queue_win #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .N_CH(NC), .FLAG_W(FW),
                      .CNT_W(CW), .TIMEOUT(0)) dut_nto (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_valid_i(n_aw_valid), .aw_ready_o(n_aw_ready), .aw_id_i(4'd9), .aw_addr_i(12'h020),
    .aw_burst_i(INCR),
    .w_valid_i(n_w_valid), .w_ready_o(n_w_ready), .w_data_i(n_w_data), .w_strb_i(4'hF),
    .w_last_i(1'b1),
    .b_valid_o(n_b_valid), .b_ready_i(1'b1), .b_id_o(n_b_id), .b_resp_o(n_b_resp),
    .ar_valid_i(1'b0), .ar_ready_o(n_ar_ready), .ar_id_i(4'd0), .ar_addr_i(12'h0),
    .ar_len_i(8'd0), .ar_burst_i(INCR),
    .r_valid_o(n_r_valid), .r_ready_i(1'b1), .r_id_o(n_r_id), .r_data_o(n_r_data),
    .r_resp_o(n_r_resp), .r_last_o(n_r_last),
    .sync_flag_i(8'd0), .rx_count_i(16'd0), .ctrl_o(n_ctrl),
    .rxq_valid_i(2'b00), .rxq_ready_o(n_rxq_ready), .rxq_data_i(64'd0),
    .txq_valid_o(n_txq_valid), .txq_ready_i(n_txq_ready), .txq_data_o(n_txq_data)
  );

  int n_tests = 0, n_fail = 0;

  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endfunction

  // receive stream models
  logic [DW-1:0] rxa[$], rxb[$];
  logic [NC-1:0] rx_pend = 0;

  function automatic void rx_refresh();
    rxq_valid = {rxb.size() != 0, rxa.size() != 0};
    rxq_data  = {(rxb.size() != 0) ? rxb[0] : 32'h0, (rxa.size() != 0) ? rxa[0] : 32'h0};
    rx_count  = {8'(rxb.size()), 8'(rxa.size())};
  endfunction

  always @(negedge clk) rx_pend = rxq_valid & rxq_ready;
  always @(posedge clk) begin
    #1;
    if (rx_pend[0]) void'(rxa.pop_front());
    if (rx_pend[1]) void'(rxb.pop_front());
    rx_pend = 0;
    rx_refresh();
  end

  // scoreboard
  logic [DW-1:0] er_data[$];
  logic          er_last[$];
  logic [IW-1:0] er_id[$];
  string         er_tag[$];
  logic [1:0]    eb_resp[$];
  logic [IW-1:0] eb_id[$];
  string         eb_tag[$];
  int            et_ch[$];
  logic [DW-1:0] et_data[$];
  string         et_tag[$];

  function automatic void exp_r(logic [DW-1:0] d, logic l, logic [IW-1:0] id, string t);
    er_data.push_back(d); er_last.push_back(l); er_id.push_back(id); er_tag.push_back(t);
  endfunction
  function automatic void exp_b(logic [1:0] r, logic [IW-1:0] id, string t);
    eb_resp.push_back(r); eb_id.push_back(id); eb_tag.push_back(t);
  endfunction
  function automatic void exp_t(int c, logic [DW-1:0] d, string t);
    et_ch.push_back(c); et_data.push_back(d); et_tag.push_back(t);
  endfunction

  always @(negedge clk) begin
    if (rst_n && r_valid && r_ready) begin
      if (er_data.size() == 0) chk(0, "R9 unexpected R beat", r_data, 0);
      else begin
        automatic string t = er_tag.pop_front();
        automatic logic [DW-1:0] d = er_data.pop_front();
        automatic logic l = er_last.pop_front();
        automatic logic [IW-1:0] id = er_id.pop_front();
        chk(r_data == d, {t, " rdata"}, r_data, d);
        chk(r_last == l, "R9 rlast", r_last, l);
        chk(r_id == id, "R9 rid", r_id, id);
        chk(r_resp == 2'b00, "R10 rresp", r_resp, 0);
      end
    end
    if (rst_n && b_valid && b_ready) begin
      if (eb_resp.size() == 0) chk(0, "R6 unexpected B", b_resp, 0);
      else begin
        automatic string t = eb_tag.pop_front();
        automatic logic [1:0] r = eb_resp.pop_front();
        automatic logic [IW-1:0] id = eb_id.pop_front();
        chk(b_resp == r, {t, " bresp"}, b_resp, r);
        chk(b_id == id, "R9 bid", b_id, id);
      end
    end
    for (int c = 0; c < NC; c++)
      if (rst_n && txq_valid[c] && txq_ready[c]) begin
        if (et_ch.size() == 0) chk(0, "R5 unexpected push", c, 99);
        else begin
          automatic string t = et_tag.pop_front();
          automatic int ec = et_ch.pop_front();
          automatic logic [DW-1:0] ed = et_data.pop_front();
          chk(c == ec, {t, " channel"}, c, ec);
          chk(txq_data[c*DW +: DW] == ed, {t, " push data"}, txq_data[c*DW +: DW], ed);
        end
      end
  end

  // drivers
  logic [DW-1:0] wb_d[8];
  logic [3:0]    wb_s[8];
  int            ww[8];

  task automatic rd_go(logic [AW-1:0] a, logic [7:0] len, logic [1:0] bt, logic [IW-1:0] id);
    @(posedge clk); #1;
    ar_valid = 1; ar_addr = a; ar_len = len; ar_burst = bt; ar_id = id;
    do @(negedge clk); while (!ar_ready);
    @(posedge clk); #1 ar_valid = 0;
    while (er_data.size() != 0) @(negedge clk);
  endtask

  task automatic wr_go(logic [AW-1:0] a, logic [1:0] bt, logic [IW-1:0] id, int n);
    @(posedge clk); #1;
    aw_valid = 1; aw_addr = a; aw_burst = bt; aw_id = id;
    do @(negedge clk); while (!aw_ready);
    @(posedge clk); #1 aw_valid = 0;
    for (int i = 0; i < n; i++) begin
      w_valid = 1; w_data = wb_d[i]; w_strb = wb_s[i]; w_last = (i == n - 1);
      ww[i] = 0;
      forever begin
        @(negedge clk);
        if (w_ready) break;
        ww[i]++;
      end
      @(posedge clk); #1;
    end
    w_valid = 0; w_last = 0;
    while (eb_resp.size() != 0) @(negedge clk);
  endtask

  task automatic ctrl_wr(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] s, string t);
    wb_d[0] = d; wb_s[0] = s;
    exp_b(2'b00, 4'd1, t);
    wr_go(a, INCR, 4'd1, 1);
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    sync_flag = 8'hA5;
    rxa.push_back(32'h1111_0001); rxa.push_back(32'h1111_0002); rxa.push_back(32'h1111_0003);
    rxb.push_back(32'h2222_0001);
    rx_refresh();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ctrl == '0, "R3 control reset", ctrl, 0);
    chk(!b_valid && !r_valid, "R10 idle after reset", {b_valid, r_valid}, 0);

    // R1 R2 status segment walked by INCR burst
    exp_r(32'hA5, 0, 4'd2, "R2 flag word");
    exp_r(32'd3,  0, 4'd2, "R2 count ch0");
    exp_r(32'd1,  0, 4'd2, "R2 count ch1");
    exp_r(32'd0,  1, 4'd2, "R2 padding word");
    rd_go(12'h000, 8'd3, INCR, 4'd2);

    // R3 control words with strobes
    ctrl_wr(12'h010, 32'h1122_3344, 4'hF, "R3 full write");
    @(negedge clk);
    chk(ctrl[31:0] == 32'h1122_3344, "R3 ctrl0 output", ctrl[31:0], 32'h1122_3344);
    ctrl_wr(12'h014, 32'hAABB_CCDD, 4'b0101, "R3 partial write");
    @(negedge clk);
    chk(ctrl[63:32] == 32'h00BB_00DD, "R3 strobe merge", ctrl[63:32], 32'h00BB_00DD);
    ctrl_wr(12'h014, 32'hEE00_0000, 4'b1000, "R3 top byte");
    exp_r(32'h1122_3344, 0, 4'd4, "R3 readback ctrl0");
    exp_r(32'hEEBB_00DD, 1, 4'd4, "R3 readback ctrl1");
    rd_go(12'h010, 8'd1, INCR, 4'd4);

    // R4 R9 single pop then FIXED drain
    exp_r(32'h2222_0001, 1, 4'd6, "R4 pop ch1");
    rd_go(12'h01C, 8'd0, INCR, 4'd6);
    exp_r(32'h1111_0001, 0, 4'd7, "R4 fixed drain 1");
    exp_r(32'h1111_0002, 0, 4'd7, "R4 fixed drain 2");
    exp_r(32'h1111_0003, 1, 4'd7, "R4 fixed drain 3");
    rd_go(12'h018, 8'd2, FIXED, 4'd7);
    exp_r(32'd0, 1, 4'd7, "R4 count after drain");
    rd_go(12'h004, 8'd0, INCR, 4'd7);

    // R4 empty receive stalls RVALID
    exp_r(32'h5555_AAAA, 1, 4'd3, "R4 late data");
    @(posedge clk); #1;
    ar_valid = 1; ar_addr = 12'h01C; ar_len = 0; ar_burst = INCR; ar_id = 4'd3;
    do @(negedge clk); while (!ar_ready);
    @(posedge clk); #1 ar_valid = 0;
    repeat (5) @(negedge clk);
    chk(r_valid == 1'b0, "R4 empty stream stalls", r_valid, 0);
    @(posedge clk); #1 rxb.push_back(32'h5555_AAAA); rx_refresh();
    while (er_data.size() != 0) @(negedge clk);

    // R5 R9 INCR write across two transmit words
    wb_d[0] = 32'hD0D0_0000; wb_s[0] = 4'hF;
    wb_d[1] = 32'hD1D1_0001; wb_s[1] = 4'hF;
    exp_t(0, 32'hD0D0_0000, "R5 push ch0");
    exp_t(1, 32'hD1D1_0001, "R5 push ch1");
    exp_b(2'b00, 4'd8, "R10 tx write");
    wr_go(12'h020, INCR, 4'd8, 2);
    chk(et_ch.size() == 0, "R5 all pushes seen", et_ch.size(), 0);

    // R5 full stream stalls W, then resumes
    txq_ready = 2'b00;
    wb_d[0] = 32'hBEEF_0005; wb_s[0] = 4'hF;
    exp_t(0, 32'hBEEF_0005, "R5 push after stall");
    exp_b(2'b00, 4'd10, "R5 stalled write okay");
    fork
      wr_go(12'h020, INCR, 4'd10, 1);
      begin
        repeat (6) @(negedge clk);
        chk(w_ready == 1'b0, "R5 full stream stalls W", w_ready, 0);
        @(posedge clk); #1 txq_ready = 2'b11;
      end
    join
    chk(ww[0] > 0, "R5 beat waited", ww[0], 1);

    // R6 watchdog abort of a FIXED burst
    txq_ready = 2'b00;
    for (int i = 0; i < 3; i++) begin wb_d[i] = 32'hDEAD_0000 + i; wb_s[i] = 4'hF; end
    exp_b(2'b10, 4'd5, "R6 abort");
    wr_go(12'h020, FIXED, 4'd5, 3);
    chk(ww[0] == TO, "R6 stall length", ww[0], TO);
    chk(ww[1] == 0 && ww[2] == 0, "R6 tail drained", {ww[1], ww[2]}, 0);
    chk(et_ch.size() == 0, "R6 no push", et_ch.size(), 0);
    txq_ready = 2'b11;
    ctrl_wr(12'h010, 32'h0000_0077, 4'b0001, "R10 okay after abort");
    @(negedge clk);
    chk(ctrl[31:0] == 32'h1122_3377, "R3 byte0 only", ctrl[31:0], 32'h1122_3377);

    // R8 out of range and misaligned
    exp_r(32'd0, 1, 4'd11, "R8 read beyond top");
    rd_go(12'h028, 8'd0, INCR, 4'd11);
    exp_r(32'd0, 1, 4'd11, "R8 misaligned read");
    rd_go(12'h011, 8'd0, INCR, 4'd11);
    ctrl_wr(12'h012, 32'hFFFF_FFFF, 4'hF, "R8 misaligned write okay");
    ctrl_wr(12'h028, 32'hFFFF_FFFF, 4'hF, "R8 out of range write okay");
    @(negedge clk);
    chk(ctrl == {32'hEEBB_00DD, 32'h1122_3377}, "R8 writes ignored", ctrl,
        {32'hEEBB_00DD, 32'h1122_3377});

    // R7 watchdog disabled instance waits indefinitely
    begin
      int early;
      early = 0;
      @(posedge clk); #1 n_aw_valid = 1;
      do @(negedge clk); while (!n_aw_ready);
      @(posedge clk); #1 n_aw_valid = 0; n_w_valid = 1; n_w_data = 32'hC0DE_0007;
      repeat (3 * TO) begin
        @(negedge clk);
        if (n_w_ready) early++;
      end
      chk(early == 0, "R7 no forced accept", early, 0);
      @(posedge clk); #1 n_txq_ready = 2'b01;
      @(negedge clk);
      chk(n_w_ready && n_txq_valid[0] && n_txq_data[31:0] == 32'hC0DE_0007,
          "R7 push when space", {n_w_ready, n_txq_valid[0], n_txq_data[31:0]},
          {1'b1, 1'b1, 32'hC0DE_0007});
      @(posedge clk); #1 n_w_valid = 0;
      @(negedge clk);
      chk(n_b_valid && n_b_resp == 2'b00, "R7 okay response", {n_b_valid, n_b_resp}, 3'b100);
    end

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule